// File: doc/BRIEF.md
# Click-Driven Zoom Controller

This block keeps the view of a fractal renderer: a complex centre point and a radius. Mouse clicks arrive already decoded, as one-cycle pulses for each button, together with the pointer position. When it accepts a click, the controller takes the renderer's pixel-to-complex converter away from the plotter for two cycles and feeds it the pointer position. It stores the converted point as the new centre. A left click halves the radius and a right click doubles it. The controller then sends a one-cycle pulse that restarts the plot.

The converter lies outside the block and is combinational. It sees the coordinate pair that the block's mux selects, and it uses the old centre and radius, so the centre is captured before the radius changes. The `ABORT_ON_BUSY` parameter sets what happens to a click that arrives while a frame is still drawing. With the default of 0 the click is parked and served once the frame ends. With 1 it is served at once, and the restart pulse abandons the current frame.

Top module: `zoom_ctrl`

## Requirements
- R1: After reset, the centre is (0,0), the radius is 2.0 (the value 2^(FRAC_W+1) in unsigned fixed point with FRAC_W fraction bits), the converter select is low and the restart output is low.
- R2: An accepted left click sets the centre to the converter output for the clicked position and halves the radius.
- R3: An accepted right click sets the centre in the same way and doubles the radius.
- R4: Doubling saturates at 2.0. A right click at that radius re-centres the view and leaves the radius at 2.0.
- R5: Halving stops after MAX_ZOOM steps, at 2.0/2^MAX_ZOOM (64 with the defaults). A left click beyond that re-centres the view and leaves the radius unchanged.
- R6: The converter select is high for exactly two cycles after a click is accepted, and in those cycles the converter coordinates are the latched pointer position. In every other cycle the plotter coordinates pass through.
- R7: The restart output is high for exactly one cycle, the fourth cycle after the clock edge that accepts the click.
- R8: Clicks that arrive while an update is in progress are ignored.
- R9: With ABORT_ON_BUSY=0, a click that arrives while the renderer is busy is parked together with its position and button. It is served once busy falls. Further clicks that arrive while a click is parked are dropped.
- R10: With ABORT_ON_BUSY=1, a click is served at once even while the renderer is busy.
- R11: If both buttons are pressed in the same cycle, the click counts as a left click.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| click_left | input | 1 | One-cycle left-button pulse |
| click_right | input | 1 | One-cycle right-button pulse |
| mouse_x | input | XW | Pointer column |
| mouse_y | input | YW | Pointer row |
| plot_x | input | XW | Plotter column for the converter |
| plot_y | input | YW | Plotter row for the converter |
| plot_busy | input | 1 | Renderer is drawing a frame |
| conv_re | input | CW | Converter real output, signed fixed point |
| conv_im | input | CW | Converter imaginary output, signed fixed point |
| conv_sel | output | 1 | High while the pointer path feeds the converter |
| conv_x | output | XW | Column fed to the converter |
| conv_y | output | YW | Row fed to the converter |
| centre_re | output | CW | Centre real part |
| centre_im | output | CW | Centre imaginary part |
| radius | output | CW | View radius, unsigned fixed point |
| plot_restart | output | 1 | One-cycle plot restart pulse |

## Verification
The embedded assertions check on every cycle the following rules:
- The radius stays between its floor and 2.0, and it changes only by a factor of two.
- The centre changes only on the cycle after the capture state.
- The restart pulse never lasts two cycles.
- A click is accepted only when the controller is idle.
- In wait mode, nothing is accepted while the renderer is busy.

Only the bench scenarios can show the rest:
- The captured centre really is the converted pointer position.
- A parked click keeps the position it had when it was made.
- Both saturation limits hold.
- The restart pulse lands in the right cycle.
- Abort mode serves a click while the renderer is busy.

// File: rtl/zoom_ctrl_pkg.sv
// Package: shared state encoding for the zoom controller.
// Assumes: used by zoom_ctrl only.
package zoom_ctrl_pkg;
    typedef enum logic [2:0] {
        ZS_IDLE,
        ZS_PICK_MOUSE,
        ZS_GRAB_CENTRE,
        ZS_RESCALE,
        ZS_KICK_PLOT
    } zoom_state_e;
endpackage

// File: rtl/zoom_click_gate.sv
// zoom_click_gate: decides when a click is accepted. In wait mode a click
// that arrives while the renderer is busy is parked, with its position and
// button, and is released when busy falls. In abort mode it passes at once.
// Assumes: click inputs are single-cycle pulses and fsm_idle is high only in
// the idle state, so clicks seen outside idle are dropped.
module zoom_click_gate #(
    parameter int XW            = 10,
    parameter int YW            = 9,
    parameter int ABORT_ON_BUSY = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          click_left,
    input  logic          click_right,
    input  logic [XW-1:0] mouse_x,
    input  logic [YW-1:0] mouse_y,
    input  logic          plot_busy,
    input  logic          fsm_idle,
    output logic          go,
    output logic          go_zoom_in,
    output logic [XW-1:0] go_x,
    output logic [YW-1:0] go_y
);
    localparam bit ABORT = (ABORT_ON_BUSY != 0);

    logic          pend_q;
    logic          pend_in_q;
    logic [XW-1:0] pend_x_q;
    logic [YW-1:0] pend_y_q;
    logic          any_click;
    logic          serve_pend;
    logic          take_new;
    logic          park_new;

    // Classify this cycle's click: serve the parked one, take a new one, or park it.
    always_comb begin
        any_click  = click_left | click_right;
        serve_pend = fsm_idle & pend_q & ~plot_busy;
        take_new   = fsm_idle & ~pend_q & any_click & (ABORT | ~plot_busy);
        park_new   = fsm_idle & ~pend_q & any_click & ~ABORT & plot_busy;
        go         = serve_pend | take_new;
        go_zoom_in = serve_pend ? pend_in_q : click_left;
        go_x       = serve_pend ? pend_x_q  : mouse_x;
        go_y       = serve_pend ? pend_y_q  : mouse_y;
    end

    // Single-entry park slot for a click that waits for the frame to finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q    <= 1'b0;
            pend_in_q <= 1'b0;
            pend_x_q  <= '0;
            pend_y_q  <= '0;
        end else if (park_new) begin
            pend_q    <= 1'b1;
            pend_in_q <= click_left;
            pend_x_q  <= mouse_x;
            pend_y_q  <= mouse_y;
        end else if (serve_pend) begin
            pend_q    <= 1'b0;
        end
    end

    generate
        if (!ABORT) begin : g_wait_chk
            AST_WAIT_NO_GO: assert property (@(posedge clk) disable iff (!rst_n)
                plot_busy |-> !go); // R9
        end
    endgenerate
endmodule

// File: rtl/zoom_coord_mux.sv
// zoom_coord_mux: picks the coordinate pair that drives the external
// pixel-to-complex converter, either the plotter's or the latched pointer's.
// Assumes: sel comes from a register, so the converter input is glitch free.
module zoom_coord_mux #(
    parameter int XW = 10,
    parameter int YW = 9
) (
    input  logic          sel,
    input  logic [XW-1:0] plot_x,
    input  logic [YW-1:0] plot_y,
    input  logic [XW-1:0] mouse_x,
    input  logic [YW-1:0] mouse_y,
    output logic [XW-1:0] conv_x,
    output logic [YW-1:0] conv_y
);
    // Route the selected source to the converter.
    always_comb begin
        conv_x = sel ? mouse_x : plot_x;
        conv_y = sel ? mouse_y : plot_y;
    end
endmodule

// File: rtl/zoom_radius_scale.sv
// zoom_radius_scale: holds the zoom depth as a step count and derives the
// radius as 2.0 shifted right by that count. The count saturates at 0
// (home view) and at MAX_ZOOM.
// Assumes: step is a single-cycle pulse; MAX_ZOOM <= FRAC_W+1.
module zoom_radius_scale #(
    parameter int CW       = 32,
    parameter int FRAC_W   = 28,
    parameter int MAX_ZOOM = 23
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          zoom_in,
    output logic [CW-1:0] radius
);
    localparam int            LVL_W   = $clog2(MAX_ZOOM + 1);
    localparam logic [CW-1:0] HOME    = CW'(1) << (FRAC_W + 1);
    localparam logic [CW-1:0] FLOOR   = HOME >> MAX_ZOOM;
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(MAX_ZOOM);

    logic [LVL_W-1:0] level_q;

    // Move the zoom depth one step per request, clamped at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level_q <= '0;
        end else if (step) begin
            if (zoom_in && level_q < LVL_MAX)
                level_q <= level_q + 1'b1;
            else if (!zoom_in && level_q != '0)
                level_q <= level_q - 1'b1;
        end
    end

    // Radius is the home radius divided by 2^depth.
    assign radius = HOME >> level_q;

    AST_RADIUS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (radius <= HOME) && (radius >= FLOOR)); // R4 R5
    AST_RADIUS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (radius != $past(radius)) |->
        ((radius == ($past(radius) << 1)) || (radius == ($past(radius) >> 1)))); // R2
endmodule

// File: rtl/zoom_ctrl.sv
// zoom_ctrl: top of the click-driven zoom controller. Sequence per click:
// idle -> select pointer path -> capture converted centre -> rescale radius
// -> pulse plot restart -> idle. The pointer path is selected one full
// cycle before capture so the converter output can settle.
// Assumes: the external converter is combinational from conv_x/conv_y and
// the current centre/radius to conv_re/conv_im.
module zoom_ctrl
    import zoom_ctrl_pkg::*;
#(
    parameter int CW            = 32,
    parameter int FRAC_W        = 28,
    parameter int MAX_ZOOM      = 23,
    parameter int XW            = 10,
    parameter int YW            = 9,
    parameter int ABORT_ON_BUSY = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          click_left,
    input  logic          click_right,
    input  logic [XW-1:0] mouse_x,
    input  logic [YW-1:0] mouse_y,
    input  logic [XW-1:0] plot_x,
    input  logic [YW-1:0] plot_y,
    input  logic          plot_busy,
    input  logic [CW-1:0] conv_re,
    input  logic [CW-1:0] conv_im,
    output logic          conv_sel,
    output logic [XW-1:0] conv_x,
    output logic [YW-1:0] conv_y,
    output logic [CW-1:0] centre_re,
    output logic [CW-1:0] centre_im,
    output logic [CW-1:0] radius,
    output logic          plot_restart
);
    zoom_state_e   state_q;
    logic          go;
    logic          go_zoom_in;
    logic [XW-1:0] go_x;
    logic [YW-1:0] go_y;
    logic [XW-1:0] mx_q;
    logic [YW-1:0] my_q;
    logic          zin_q;
    logic          fsm_idle;

    assign fsm_idle = (state_q == ZS_IDLE);

    zoom_click_gate #(.XW(XW), .YW(YW), .ABORT_ON_BUSY(ABORT_ON_BUSY)) gate_i (
        .clk(clk), .rst_n(rst_n),
        .click_left(click_left), .click_right(click_right),
        .mouse_x(mouse_x), .mouse_y(mouse_y),
        .plot_busy(plot_busy), .fsm_idle(fsm_idle),
        .go(go), .go_zoom_in(go_zoom_in), .go_x(go_x), .go_y(go_y)
    );

    zoom_coord_mux #(.XW(XW), .YW(YW)) mux_i (
        .sel(conv_sel), .plot_x(plot_x), .plot_y(plot_y),
        .mouse_x(mx_q), .mouse_y(my_q),
        .conv_x(conv_x), .conv_y(conv_y)
    );

    zoom_radius_scale #(.CW(CW), .FRAC_W(FRAC_W), .MAX_ZOOM(MAX_ZOOM)) scale_i (
        .clk(clk), .rst_n(rst_n),
        .step(state_q == ZS_RESCALE), .zoom_in(zin_q),
        .radius(radius)
    );

    // Sequencer for one zoom update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ZS_IDLE;
        end else begin
            unique case (state_q)
                ZS_IDLE:        if (go) state_q <= ZS_PICK_MOUSE;
                ZS_PICK_MOUSE:  state_q <= ZS_GRAB_CENTRE;
                ZS_GRAB_CENTRE: state_q <= ZS_RESCALE;
                ZS_RESCALE:     state_q <= ZS_KICK_PLOT;
                ZS_KICK_PLOT:   state_q <= ZS_IDLE;
                default:        state_q <= ZS_IDLE;
            endcase
        end
    end

    // Latch position and direction of the accepted click.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mx_q  <= '0;
            my_q  <= '0;
            zin_q <= 1'b0;
        end else if (go) begin
            mx_q  <= go_x;
            my_q  <= go_y;
            zin_q <= go_zoom_in;
        end
    end

    // Capture the settled converter output as the new view centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            centre_re <= '0;
            centre_im <= '0;
        end else if (state_q == ZS_GRAB_CENTRE) begin
            centre_re <= conv_re;
            centre_im <= conv_im;
        end
    end

    // Mux select and restart pulse decoded from the state.
    always_comb begin
        conv_sel     = (state_q == ZS_PICK_MOUSE) || (state_q == ZS_GRAB_CENTRE);
        plot_restart = (state_q == ZS_KICK_PLOT);
    end

    AST_CENTRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ZS_GRAB_CENTRE) |=> ($stable(centre_re) && $stable(centre_im))); // R2
    AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        plot_restart |=> !plot_restart); // R7
    AST_GO_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> fsm_idle); // R8
    AST_SEL_BEFORE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(conv_sel) |-> !plot_restart); // R6
endmodule

// File: tb/zoom_ctrl_tb_top.sv
// Bench for zoom_ctrl: table-driven click sequence, then directed cases.
module zoom_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic        l;
        logic        r;
        logic [9:0]  x;
        logic [8:0]  y;
        logic [31:0] rad;
    } vec_t;

    // Click pattern and expected radius after it (home radius 2.0 = 2^29).
    localparam vec_t VECS [6] = '{
        '{1'b1, 1'b0, 10'd320, 9'd240, 32'h1000_0000},  // R2 left
        '{1'b1, 1'b0, 10'd400, 9'd100, 32'h0800_0000},  // R2 left
        '{1'b0, 1'b1, 10'd10,  9'd470, 32'h1000_0000},  // R3 right
        '{1'b0, 1'b1, 10'd639, 9'd0,   32'h2000_0000},  // R3 right
        '{1'b0, 1'b1, 10'd55,  9'd333, 32'h2000_0000},  // R4 saturate
        '{1'b1, 1'b1, 10'd200, 9'd20,  32'h1000_0000}   // R11 both
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        click_left = 1'b0, click_right = 1'b0;
    logic [9:0]  mouse_x = '0, plot_x = 10'd7;
    logic [8:0]  mouse_y = '0, plot_y = 9'd3;
    logic        plot_busy = 1'b0;
    logic [31:0] conv_re, conv_im, a_conv_re, a_conv_im;
    logic        conv_sel, plot_restart, a_sel, a_restart;
    logic [9:0]  conv_x, a_conv_x;
    logic [8:0]  conv_y, a_conv_y;
    logic [31:0] centre_re, centre_im, radius, a_centre_re, a_centre_im, a_radius;

    int errors = 0, checks = 0;
    int sel_n, start_n, start_at;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Model of the external converter: pixel offset from screen middle, scaled.
    function automatic logic [31:0] re_of(logic [9:0] x);
        return 32'((int'(x) - 320) * 1048576);
    endfunction
    function automatic logic [31:0] im_of(logic [8:0] y);
        return 32'((240 - int'(y)) * 1048576);
    endfunction

    assign conv_re   = re_of(conv_x);
    assign conv_im   = im_of(conv_y);
    assign a_conv_re = re_of(a_conv_x);
    assign a_conv_im = im_of(a_conv_y);

    zoom_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .click_left(click_left), .click_right(click_right),
        .mouse_x(mouse_x), .mouse_y(mouse_y), .plot_x(plot_x), .plot_y(plot_y),
        .plot_busy(plot_busy), .conv_re(conv_re), .conv_im(conv_im),
        .conv_sel(conv_sel), .conv_x(conv_x), .conv_y(conv_y),
        .centre_re(centre_re), .centre_im(centre_im), .radius(radius),
        .plot_restart(plot_restart)
    );

    zoom_ctrl #(.ABORT_ON_BUSY(1)) dut_abort_i (
        .clk(clk), .rst_n(rst_n), .click_left(click_left), .click_right(click_right),
        .mouse_x(mouse_x), .mouse_y(mouse_y), .plot_x(plot_x), .plot_y(plot_y),
        .plot_busy(plot_busy), .conv_re(a_conv_re), .conv_im(a_conv_im),
        .conv_sel(a_sel), .conv_x(a_conv_x), .conv_y(a_conv_y),
        .centre_re(a_centre_re), .centre_im(a_centre_im), .radius(a_radius),
        .plot_restart(a_restart)
    );

    task automatic check(string req, longint actual, longint expected);
        checks++;
        if (actual != expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // One click pulse, then watch six cycles of select and restart activity.
    task automatic do_click(logic l, logic r, logic [9:0] x, logic [8:0] y, bit chk_sel);
        @(negedge clk);
        click_left = l; click_right = r; mouse_x = x; mouse_y = y;
        sel_n = 0; start_n = 0; start_at = 0;
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            if (i == 1) begin
                click_left = 1'b0; click_right = 1'b0; mouse_x = 10'd1; mouse_y = 9'd1;
                if (chk_sel) check("R6 conv_x latched", conv_x, x);
            end
            if (conv_sel) sel_n++;
            if (plot_restart) begin start_n++; start_at = i; end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] keep_re;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 centre_re", centre_re, 0);
        check("R1 centre_im", centre_im, 0);
        check("R1 radius", radius, 32'h2000_0000);
        check("R1 conv_sel", conv_sel, 0);
        check("R1 plot_restart", plot_restart, 0);
        rst_n = 1'b1;

        // Table walk: R2 R3 R4 R11 plus R6 R7 timing on each click
        for (int k = 0; k < 6; k++) begin
            do_click(VECS[k].l, VECS[k].r, VECS[k].x, VECS[k].y, 1'b1);
            check("R2/R3 centre_re", centre_re, re_of(VECS[k].x));
            check("R2/R3 centre_im", centre_im, im_of(VECS[k].y));
            check("R2/R3/R4/R11 radius", radius, VECS[k].rad);
            check("R6 select cycles", sel_n, 2);
            check("R7 restart count", start_n, 1);
            check("R7 restart cycle", start_at, 4);
        end
        check("R6 plot path passes", conv_x, plot_x);

        // R5: deep zoom stops at 2.0/2^23 = 64
        for (int k = 0; k < 25; k++) do_click(1'b1, 1'b0, 10'd321, 9'd239, 1'b0);
        check("R5 radius floor", radius, 64);
        check("R5 centre still updated", centre_re, re_of(10'd321));

        // R8: a right click during an update is ignored
        do_click(1'b0, 1'b1, 10'd330, 9'd240, 1'b0);   // radius 128
        @(negedge clk);
        click_left = 1'b1; mouse_x = 10'd300; mouse_y = 9'd200;
        @(negedge clk);
        click_left = 1'b0;
        @(negedge clk);
        click_right = 1'b1; mouse_x = 10'd0;
        @(negedge clk);
        click_right = 1'b0;
        repeat (5) @(negedge clk);
        check("R8 radius after ignored click", radius, 64);
        check("R8 centre from first click", centre_re, re_of(10'd300));

        // R9 wait mode and R10 abort mode
        keep_re = centre_re;
        plot_busy = 1'b1;
        do_click(1'b0, 1'b1, 10'd100, 9'd50, 1'b0);
        check("R9 no restart while busy", start_n, 0);
        check("R9 centre held while busy", centre_re, keep_re);
        check("R10 abort centre_re", a_centre_re, re_of(10'd100));
        check("R10 abort centre_im", a_centre_im, im_of(9'd50));
        do_click(1'b1, 1'b0, 10'd500, 9'd400, 1'b0);   // dropped while parked
        @(negedge clk);
        plot_busy = 1'b0;
        start_n = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk);
            if (plot_restart) start_n++;
        end
        check("R9 parked click served once", start_n, 1);
        check("R9 parked position re", centre_re, re_of(10'd100));
        check("R9 parked position im", centre_im, im_of(9'd50));
        check("R9 parked direction", radius, 128);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule